// File: doc/BRIEF.md
# Speculative Load Address Fast Path

This block sits at the front of a load port. For each load uop it computes the effective address (base, plus an optional index, plus a signed displacement). For loads that are likely to be following a pointer, it also decides whether the cache and translation lookup may start early, using the unadded base register as a guess of the page. The guess is cheap because the low twelve address bits index the cache in the same way in both the virtual and physical address. Only the page number has to be guessed, and a small positive displacement rarely changes it.

A load is eligible only when all of these hold: its base was written by an earlier load, it has no index or its index is known to be zero, and its displacement lies in 0..2047. An eligible load that stays inside its 4 KiB page returns data one cycle sooner than the normal path. An eligible load whose displacement carries into the page number lets the wrong-page access finish and is then replayed. The replay costs several cycles and a second slot on the port. A configurable history bit can hold off the next attempt after such a failure. A counter records the failed attempts, and a clear strobe resets it.

Each issued load produces one result record on the cycle after issue. The record carries the attempt decision, the replay flag, the effective address, the latency to report to the scheduler and the number of port dispatches.

Top module: `ldf_load_agu`

## Requirements
- R1: After reset, `res_valid` is 0 and `cancel_count` is 0. The history starts in the "last attempt did not fail" state, so the first eligible load in alternate mode attempts the fast path.
- R2: A load whose base came from an ALU result (`base_from_load`=0) never attempts the fast path. It reports latency 5 and dispatch count 1.
- R3: A load with `has_index`=1 is not attempted unless `idx_known_zero`=1. When it is attempted, the index value is treated as zero.
- R4: A load is attempted only when its displacement, read as a two's-complement number, is in 0..2047, i.e. every bit from bit 11 up is zero. Negative displacements and displacements of 2048 or more take the normal path (latency 5).
- R5: An attempted load whose effective address lies in the same 4 KiB page as its base reports latency 4, `res_replay`=0 and dispatch count 1. This includes loads that cross a 64-byte line inside that page.
- R6: An attempted load whose address bits [11:0] plus the displacement carry into bit 12 reports `res_replay`=1 and dispatch count 2. Its latency is 9 when `alt_mode`=0.
- R7: With `alt_mode`=1, a replayed load reports latency 10. The load issued right after a failed attempt does not attempt the fast path. A run of page-crossing loads therefore reports 10, 5, 10, 5...
- R8: With `fp_en`=0, no load is attempted and every load reports latency 5.
- R9: `res_addr` equals base + (index if `has_index`) + sign-extended displacement, modulo 2^ADDR_W, and it appears on the cycle after issue together with `res_valid`.
- R10: `cancel_count` rises by one on the cycle after each failed attempt. `cancel_clr` sets it to 0 at the next edge and wins over a failure in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fp_en | input | 1 | Static enable of the fast path |
| alt_mode | input | 1 | Static mode: 10-cycle replay and suppression after a failure |
| issue_valid | input | 1 | A load uop is presented this cycle |
| base | input | ADDR_W | Base register value |
| disp | input | DISP_W | Signed displacement |
| has_index | input | 1 | Addressing form uses an index register |
| idx | input | ADDR_W | Index register value |
| idx_known_zero | input | 1 | Index register is known to hold zero |
| base_from_load | input | 1 | Base value was produced by a load |
| cancel_clr | input | 1 | Clears the failed-attempt counter |
| res_valid | output | 1 | Result record valid |
| res_spec | output | 1 | Fast path was attempted |
| res_replay | output | 1 | Attempt failed and the load is replayed |
| res_addr | output | ADDR_W | Effective address |
| res_latency | output | 4 | Load-to-use latency for the scheduler |
| res_dispatch | output | 2 | Port dispatches used by this load |
| cancel_count | output | CNT_W | Failed-attempt counter |

## Verification
Every result record is registered once, so it appears exactly one clock edge after the cycle in which `issue_valid` is sampled. The counter and the history bit change at that same edge. The bench drives on the falling edge and queues the expected record at issue time. A monitor compares the queued record on the next falling edge on which `res_valid` is high. Counter checks are made one falling edge after the load or clear strobe that affects them. The history is modelled in the bench from its own page-number comparison, so the alternating 10/5 pattern is predicted without looking at the design.

// File: rtl/ldf_pkg.sv
package ldf_pkg;

  localparam int PAGE_BITS = 12;
  localparam int SMALL_BITS = 11;
  localparam int LAT_W = 4;
  localparam int DSP_W = 2;

  localparam logic [LAT_W-1:0] LAT_FAST = 4'd4;
  localparam logic [LAT_W-1:0] LAT_NORMAL = 4'd5;
  localparam logic [LAT_W-1:0] LAT_REPLAY = 4'd9;
  localparam logic [LAT_W-1:0] LAT_REPLAY_ALT = 4'd10;

  // carry from the in-page offset into the page number
  function automatic logic page_carry(input logic [PAGE_BITS-1:0] b_lo,
                                      input logic [PAGE_BITS-1:0] d_lo);
    logic [PAGE_BITS:0] s;
    s = {1'b0, b_lo} + {1'b0, d_lo};
    return s[PAGE_BITS];
  endfunction

  function automatic logic [LAT_W-1:0] pick_latency(input logic tried,
                                                     input logic failed,
                                                     input logic alt);
    if (!tried) return LAT_NORMAL;
    if (!failed) return LAT_FAST;
    return alt ? LAT_REPLAY_ALT : LAT_REPLAY;
  endfunction

  function automatic logic [DSP_W-1:0] pick_dispatch(input logic failed);
    return failed ? 2'd2 : 2'd1;
  endfunction

endpackage

// File: rtl/ldf_gate.sv
module ldf_gate #(
  parameter int DISP_W = 32
) (
  input  logic              fp_en,
  input  logic              base_from_load,
  input  logic              has_index,
  input  logic              idx_known_zero,
  input  logic [DISP_W-1:0] disp,
  output logic              eligible
);
  import ldf_pkg::*;

  localparam int HI_W = DISP_W - SMALL_BITS;

  logic disp_small;
  logic form_ok;

  // zero-test of the upper bits only: no adder, no comparator
  assign disp_small = (disp[DISP_W-1:SMALL_BITS] == {HI_W{1'b0}});
  assign form_ok = !has_index || idx_known_zero;
  assign eligible = fp_en && base_from_load && form_ok && disp_small;

endmodule

// File: rtl/ldf_addr.sv
module ldf_addr #(
  parameter int ADDR_W = 48,
  parameter int DISP_W = 32
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] idx,
  input  logic              use_idx,
  input  logic [DISP_W-1:0] disp,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              page_cross
);
  import ldf_pkg::*;

  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] disp_ext;
  logic [ADDR_W-1:0] idx_term;

  assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
  assign idx_term = use_idx ? idx : '0;
  assign eff_addr = base + idx_term + disp_ext;
  assign page_cross = page_carry(base[PAGE_BITS-1:0], disp[PAGE_BITS-1:0]);

endmodule

// File: rtl/ldf_track.sv
module ldf_track #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_valid,
  input  logic             spec_fail,
  input  logic             cancel_clr,
  output logic             hist_fail,
  output logic [CNT_W-1:0] cancel_count
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_fail <= 1'b0;
    end else if (issue_valid) begin
      hist_fail <= spec_fail;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cancel_count <= '0;
    end else if (cancel_clr) begin
      cancel_count <= '0;
    end else if (spec_fail) begin
      cancel_count <= cancel_count + 1'b1;
    end
  end

endmodule

// File: rtl/ldf_load_agu.sv
module ldf_load_agu #(
  parameter int ADDR_W = 48,
  parameter int DISP_W = 32,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fp_en,
  input  logic              alt_mode,
  input  logic              issue_valid,
  input  logic [ADDR_W-1:0] base,
  input  logic [DISP_W-1:0] disp,
  input  logic              has_index,
  input  logic [ADDR_W-1:0] idx,
  input  logic              idx_known_zero,
  input  logic              base_from_load,
  input  logic              cancel_clr,
  output logic              res_valid,
  output logic              res_spec,
  output logic              res_replay,
  output logic [ADDR_W-1:0] res_addr,
  output logic [3:0]        res_latency,
  output logic [1:0]        res_dispatch,
  output logic [CNT_W-1:0]  cancel_count
);
  import ldf_pkg::*;

  logic              eligible;
  logic              hist_fail;
  logic              spec_try;
  logic              spec_fail;
  logic              page_cross;
  logic              use_idx;
  logic [ADDR_W-1:0] eff_addr;

  ldf_gate #(.DISP_W(DISP_W)) i_gate (
    .fp_en(fp_en),
    .base_from_load(base_from_load),
    .has_index(has_index),
    .idx_known_zero(idx_known_zero),
    .disp(disp),
    .eligible(eligible)
  );

  assign use_idx = has_index && !idx_known_zero;

  ldf_addr #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) i_addr (
    .base(base),
    .idx(idx),
    .use_idx(use_idx),
    .disp(disp),
    .eff_addr(eff_addr),
    .page_cross(page_cross)
  );

  assign spec_try = issue_valid && eligible && !(alt_mode && hist_fail);
  assign spec_fail = spec_try && page_cross;

  ldf_track #(.CNT_W(CNT_W)) i_track (
    .clk(clk),
    .rst_n(rst_n),
    .issue_valid(issue_valid),
    .spec_fail(spec_fail),
    .cancel_clr(cancel_clr),
    .hist_fail(hist_fail),
    .cancel_count(cancel_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_spec <= 1'b0;
      res_replay <= 1'b0;
      res_addr <= '0;
      res_latency <= '0;
      res_dispatch <= '0;
    end else begin
      res_valid <= issue_valid;
      if (issue_valid) begin
        res_spec <= spec_try;
        res_replay <= spec_fail;
        res_addr <= eff_addr;
        res_latency <= pick_latency(spec_try, spec_fail, alt_mode);
        res_dispatch <= pick_dispatch(spec_fail);
      end
    end
  end

endmodule

// File: rtl/ldf_load_agu_chk.sv
module ldf_load_agu_chk #(
  parameter int ADDR_W = 48,
  parameter int DISP_W = 32,
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              alt_mode,
  input logic              fp_en,
  input logic              issue_valid,
  input logic [ADDR_W-1:0] base,
  input logic [DISP_W-1:0] disp,
  input logic              base_from_load,
  input logic              cancel_clr,
  input logic              res_valid,
  input logic              res_spec,
  input logic              res_replay,
  input logic [ADDR_W-1:0] res_addr,
  input logic [3:0]        res_latency,
  input logic [1:0]        res_dispatch,
  input logic [CNT_W-1:0]  cancel_count,
  input logic              spec_fail
);

  // R2
  alu_base_no_try_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && !base_from_load |=> res_valid && !res_spec && res_latency == 4'd5);

  // R4
  big_disp_no_try_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && (disp[DISP_W-1:11] != '0) |=> res_valid && !res_spec);

  // R8
  fp_off_no_try_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && !fp_en |=> !res_spec);

  // R5
  fast_hit_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_spec && !res_replay |-> res_latency == 4'd4 && res_dispatch == 2'd1);

  // R5
  fast_hit_same_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid ##1 (res_spec && !res_replay) |-> res_addr[ADDR_W-1:12] == $past(base[ADDR_W-1:12]));

  // R6
  replay_double_dispatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_replay |-> res_spec && res_dispatch == 2'd2);

  // R7
  alt_replay_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_replay && alt_mode |-> res_latency == 4'd10);

  // R10
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_clr |=> cancel_count == '0);

  // R10
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spec_fail && !cancel_clr |=> cancel_count == CNT_W'($past(cancel_count) + 1'b1));

endmodule

bind ldf_load_agu ldf_load_agu_chk #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .CNT_W(CNT_W)) i_chk (
  .clk(clk),
  .rst_n(rst_n),
  .alt_mode(alt_mode),
  .fp_en(fp_en),
  .issue_valid(issue_valid),
  .base(base),
  .disp(disp),
  .base_from_load(base_from_load),
  .cancel_clr(cancel_clr),
  .res_valid(res_valid),
  .res_spec(res_spec),
  .res_replay(res_replay),
  .res_addr(res_addr),
  .res_latency(res_latency),
  .res_dispatch(res_dispatch),
  .cancel_count(cancel_count),
  .spec_fail(spec_fail)
);

// File: tb/test_ldf_load_agu.sv
`timescale 1ns/1ps
module test_ldf_load_agu;
  localparam int AW = 48;
  localparam int DW = 32;
  localparam int CW = 16;

  logic clk = 0;
  logic rst_n = 0;
  logic fp_en = 1;
  logic alt_mode = 0;
  logic issue_valid = 0;
  logic [AW-1:0] base = '0;
  logic [DW-1:0] disp = '0;
  logic has_index = 0;
  logic [AW-1:0] idx = '0;
  logic idx_known_zero = 0;
  logic base_from_load = 0;
  logic cancel_clr = 0;
  logic res_valid, res_spec, res_replay;
  logic [AW-1:0] res_addr;
  logic [3:0] res_latency;
  logic [1:0] res_dispatch;
  logic [CW-1:0] cancel_count;

  always #10 clk = ~clk;

  ldf_load_agu #(.ADDR_W(AW), .DISP_W(DW), .CNT_W(CW)) i_ldf_load_agu (
    .clk(clk), .rst_n(rst_n), .fp_en(fp_en), .alt_mode(alt_mode),
    .issue_valid(issue_valid), .base(base), .disp(disp), .has_index(has_index),
    .idx(idx), .idx_known_zero(idx_known_zero), .base_from_load(base_from_load),
    .cancel_clr(cancel_clr), .res_valid(res_valid), .res_spec(res_spec),
    .res_replay(res_replay), .res_addr(res_addr), .res_latency(res_latency),
    .res_dispatch(res_dispatch), .cancel_count(cancel_count)
  );

  typedef struct {
    logic [AW-1:0] addr;
    int lat;
    bit spec;
    bit rep;
    int nd;
    string tag;
  } exp_t;

  exp_t sb[$];
  int total = 0;
  int bad = 0;
  bit m_fail = 0;
  int m_count = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: one load, expected record computed from the requirements
  task automatic load(input string tag, input logic [AW-1:0] b, input longint d,
                      input bit from_ld, input bit hx = 0, input logic [AW-1:0] ix = '0,
                      input bit kz = 0);
    exp_t e;
    longint unsigned ea;
    bit elig, tried, crossed;
    @(negedge clk);
    issue_valid = 1; base = b; disp = DW'(d); base_from_load = from_ld;
    has_index = hx; idx = ix; idx_known_zero = kz;
    ea = longint'(b) + ((hx && !kz) ? longint'(ix) : 0) + d;
    e.addr = AW'(ea);
    elig = fp_en && from_ld && (!hx || kz) && d >= 0 && d < 2048;
    tried = elig && !(alt_mode && m_fail);
    crossed = (e.addr >> 12) != (b >> 12);
    e.spec = tried;
    e.rep = tried && crossed;
    e.lat = !tried ? 5 : (!crossed ? 4 : (alt_mode ? 10 : 9));
    e.nd = e.rep ? 2 : 1;
    e.tag = tag;
    m_fail = e.rep;
    if (e.rep) m_count++;
    sb.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    issue_valid = 0; cancel_clr = 0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (sb.size() == 0) begin
        chk(0, "R9 unexpected result", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(res_addr == e.addr, {e.tag, " R9 addr"}, res_addr, e.addr);
        chk(res_spec == e.spec, {e.tag, " spec"}, res_spec, e.spec);
        chk(res_replay == e.rep, {e.tag, " replay"}, res_replay, e.rep);
        chk(res_latency == 4'(e.lat), {e.tag, " latency"}, res_latency, e.lat);
        chk(res_dispatch == 2'(e.nd), {e.tag, " dispatch"}, res_dispatch, e.nd);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk(res_valid == 0, "R1 res_valid", res_valid, 0);
    chk(cancel_count == 0, "R1 count", cancel_count, 0);

    load("R2 alu base", 48'h1000, 8, 0);
    load("R5 same page", 48'h1000, 8, 1);
    load("R5 line cross in page", 48'h1030, 48, 1);
    load("R6 page carry", 48'h1ff8, 8, 1);
    load("R6 page carry disp0x7ff", 48'h2801, 2047, 1);
    load("R4 negative disp", 48'h2008, -8, 1);
    load("R4 disp 2048", 48'h1000, 2048, 1);
    load("R4 disp 2047", 48'h1000, 2047, 1);
    load("R3 index nonzero", 48'h1000, 8, 1, 1, 48'h10, 0);
    load("R3 index known zero", 48'h1000, 8, 1, 1, 48'h0, 1);
    load("R9 wrap", 48'hffff_ffff_fff8, 16, 1);
    idle(); idle();
    chk(cancel_count == CW'(m_count), "R10 count after fails", cancel_count, m_count);

    // R10: clear alone, then clear with a same-cycle failure
    @(negedge clk); cancel_clr = 1;
    idle();
    chk(cancel_count == 0, "R10 clear", cancel_count, 0);
    load("R6 fail with clear", 48'h3ff0, 32, 1);
    cancel_clr = 1;
    idle();
    chk(cancel_count == 0, "R10 clear wins", cancel_count, 0);
    m_count = 0;
    load("R6 fail after clear", 48'h3ff0, 32, 1);
    idle();
    chk(cancel_count == 1, "R10 single step", cancel_count, 1);

    // R8: fast path disabled
    idle(); fp_en = 0;
    load("R8 disabled", 48'h1000, 8, 1);
    load("R8 disabled cross", 48'h1ff8, 8, 1);
    idle(); fp_en = 1;

    // R7: alternate mode, crossing run then suppressed hit
    alt_mode = 1;
    for (int k = 0; k < 4; k++) load("R7 cross run", 48'h5ffc, 8, 1);
    load("R7 cross", 48'h5ffc, 8, 1);
    load("R7 after fail", 48'h5000, 8, 1);
    load("R7 hit", 48'h5000, 8, 1);
    idle(); idle();
    alt_mode = 0;

    chk(sb.size() == 0, "R9 all results seen", sb.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule